// File: doc/BRIEF.md
# Timer/Counter and Watchdog with Shared Scaler

This block holds an 8-bit timer/counter and a watchdog timer that share a single 8-bit scaler. A role bit in the block's 6-bit option register assigns the scaler to one of the two. Assigned to the timer, the scaler divides the timer's increment source by a power of two from 2 to 256. Assigned to the watchdog, it counts watchdog wraps and raises a time-out after a power of two from 1 to 128 of them. The timer either counts instruction cycles (`cyc_tick`) or counts edges of an external pin. The pin is synchronised through two flip-flops before edge detection.

The instruction decoder drives the option write, timer write, clear-watchdog and sleep strobes. Each strobe is taken only in a clock cycle where `cyc_tick` is high, because it marks the instruction that completes in that cycle. The block returns the timer value, the option value, a one-clock watchdog reset request, and update pulses for the time-out and power-down status flags. The owner of the status register applies those pulses.

Top module: `tmr_wdog`

## Requirements
- R1: After reset `tmr_q` is 0, `opt_q` is 6'h3F, no pulse output is high, the scaler count is zero, and the write hold-off is cancelled.
- R2: When `opt_we` and `cyc_tick` are both high, `opt_wdata` is loaded into the option register. The fields are: bit 5 selects the external pin as the source (1) or instruction cycles (0); bit 4 selects falling (1) or rising (0) pin edges; bit 3 assigns the scaler to the watchdog (1) or to the timer (0); bits 2..0 hold the rate. A new option takes effect from the following tick.
- R3: With the internal source and the scaler on the watchdog, the timer rises by 1 on every tick and wraps from 255 to 0.
- R4: With the scaler on the timer, the timer rises once every (2 << rate) source events, for example every 4 events at rate 1 and every 256 at rate 7.
- R5: With the external source, only the selected pin edge advances the timer, and ticks do not. The increment is visible after the third rising clock edge that follows the pin change.
- R6: A timer write (with a tick) loads `tmr_wdata`. It suppresses counting on the write tick and on the next two ticks, and the third tick after the write counts again. When the scaler is on the timer, the write also clears the scaler count.
- R7: With `wdt_en` high and the scaler on the timer, the watchdog wraps every `WDT_PERIOD` ticks. Each wrap gives a one-clock `wdt_rst_req` together with `to_upd`=1 and `to_val`=0.
- R8: With the scaler on the watchdog, a reset request is issued only after (1 << rate) watchdog wraps, for example after 4 wraps at rate 2. The scaler then returns to zero.
- R9: A clear-watchdog tick zeroes the watchdog count and, when the scaler is on the watchdog, the scaler count. The watchdog does not advance on that tick. The tick gives `to_upd`=1, `to_val`=1, `pd_upd`=1 and `pd_val`=1.
- R10: A sleep tick gives `to_upd`=1, `to_val`=1, `pd_upd`=1 and `pd_val`=0. It zeroes the watchdog count when `wdt_en` is high and clears the scaler when the scaler is on the watchdog. The watchdog does not advance on that tick.
- R11: With `wdt_en` low, the watchdog never issues a reset request.
- R12: Strobes presented without `cyc_tick` have no effect. They change neither the option register nor the timer, and they produce no flag pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | Instruction-cycle tick; qualifies all strobes |
| cnt_pin | input | 1 | Asynchronous external count input |
| opt_we | input | 1 | Option register write strobe |
| opt_wdata | input | 6 | Option register write data |
| wdt_en | input | 1 | Watchdog enable |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| clrwdt_i | input | 1 | Clear-watchdog instruction strobe |
| sleep_i | input | 1 | Sleep instruction strobe |
| tmr_q | output | 8 | Timer value |
| opt_q | output | 6 | Option register value |
| wdt_rst_req | output | 1 | One-clock device reset request on time-out |
| to_upd | output | 1 | Time-out flag update strobe |
| to_val | output | 1 | New time-out flag value |
| pd_upd | output | 1 | Power-down flag update strobe |
| pd_val | output | 1 | New power-down flag value |

## Verification
Every result of a tick is registered once. This covers a timer load or increment, an option load, a reset request and the flag pulses. Each of them is visible in the clock cycle right after the rising edge that sampled the tick. A pin change passes through two synchroniser stages and then the timer register, so its increment appears only after the third rising edge. The bench applies stimulus on falling edges and captures the one-clock pulses at the first falling edge after the tick. For the pin, it samples after the second edge, expecting the old value, and after the third, expecting the new one. Watchdog checks count reset pulses across a run of ticks. Each check sits one tick before and one tick after the computed wrap point.

// File: rtl/tmr_wdog_pkg.sv
package tmr_wdog_pkg;

    localparam int TMR_W  = 8;
    localparam int OPT_W  = 6;
    localparam int RATE_W = 3;
    localparam int SCL_W  = 1 << RATE_W;

    localparam logic [OPT_W-1:0] OPT_RESET = '1;

    // Option register; the first member is the most significant bit (bit 5).
    typedef struct packed {
        logic              ext_src;     // bit 5: 1 = external pin edges
        logic              fall_edge;   // bit 4: 1 = falling edges
        logic              scl_to_wdog; // bit 3: 1 = scaler serves the watchdog
        logic [RATE_W-1:0] rate;        // bits 2..0
    } opt_t;

    typedef enum logic {
        SCL_TMR  = 1'b0,
        SCL_WDOG = 1'b1
    } scl_role_e;

    // Division ratio: 1 << rate for the watchdog role, 2 << rate for the timer role.
    function automatic logic [SCL_W:0] scl_limit(input scl_role_e role,
                                                 input logic [RATE_W-1:0] rate);
        logic [SCL_W:0] base;
        base = (SCL_W + 1)'(1) << rate;
        return (role == SCL_WDOG) ? base : (base << 1);
    endfunction

endpackage

// File: rtl/tmr_wdog_sync.sv
module tmr_wdog_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain[0] <= pin_i;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            last <= chain[STAGES-1];
        end
    end

    assign rise_o =  chain[STAGES-1] & ~last;
    assign fall_o = ~chain[STAGES-1] &  last;
endmodule

// File: rtl/tmr_wdog_scaler.sv
module tmr_wdog_scaler
    import tmr_wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  scl_role_e         role,
    input  logic [RATE_W-1:0] rate,
    input  logic              step,
    input  logic              clear,
    output logic              done
);
    logic [SCL_W-1:0] cnt;
    logic [SCL_W:0]   nxt;
    logic             reach;

    assign nxt   = {1'b0, cnt} + (SCL_W + 1)'(1);
    // Compare with >= so that lowering the rate mid-count still terminates.
    assign reach = (nxt >= scl_limit(role, rate));
    assign done  = step && !clear && reach;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= reach ? '0 : nxt[SCL_W-1:0];
        end
    end
endmodule

// File: rtl/tmr_wdog_wdt.sv
module tmr_wdog_wdt #(
    parameter int PERIOD = 18000,
    parameter int W      = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic clear,
    output logic wrap
);
    logic [W-1:0] cnt;
    logic [W-1:0] nxt;

    // Counts down; from zero it reloads the top value, and arriving at zero is a wrap.
    assign nxt  = (cnt == '0) ? W'(PERIOD - 1) : (cnt - W'(1));
    assign wrap = step && !clear && (nxt == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= nxt;
        end
    end
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog
    import tmr_wdog_pkg::*;
#(
    parameter int WDT_PERIOD  = 18000,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_TICKS  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_tick,
    input  logic             cnt_pin,
    input  logic             opt_we,
    input  logic [OPT_W-1:0] opt_wdata,
    input  logic             wdt_en,
    input  logic             tmr_we,
    input  logic [TMR_W-1:0] tmr_wdata,
    input  logic             clrwdt_i,
    input  logic             sleep_i,
    output logic [TMR_W-1:0] tmr_q,
    output logic [OPT_W-1:0] opt_q,
    output logic             wdt_rst_req,
    output logic             to_upd,
    output logic             to_val,
    output logic             pd_upd,
    output logic             pd_val
);
    localparam int WDT_W  = (WDT_PERIOD > 1) ? $clog2(WDT_PERIOD) : 1;
    localparam int HOLD_W = $clog2(HOLD_TICKS + 1);

    opt_t              opt_r;
    scl_role_e         role;
    logic [HOLD_W-1:0] hold_cnt;
    logic              held;
    logic              pin_rise, pin_fall, edge_hit;
    logic              do_load, do_clr, do_slp;
    logic              src_evt, tmr_evt, tmr_bump;
    logic              wdt_step, wdt_clear, wdt_wrap;
    logic              scl_step, scl_clear, scl_done;
    logic              timeout;

    assign opt_q = opt_r;
    assign role  = opt_r.scl_to_wdog ? SCL_WDOG : SCL_TMR;

    always_ff @(posedge clk) begin
        if (rst) begin
            opt_r <= opt_t'(OPT_RESET);
        end else if (cyc_tick && opt_we) begin
            opt_r <= opt_t'(opt_wdata);
        end
    end

    tmr_wdog_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (cnt_pin),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    // Strobes only count in the cycle that carries an instruction tick.
    assign do_load = cyc_tick && tmr_we;
    assign do_clr  = cyc_tick && clrwdt_i;
    assign do_slp  = cyc_tick && sleep_i && !clrwdt_i;

    assign held     = (hold_cnt != '0);
    assign edge_hit = opt_r.fall_edge ? pin_fall : pin_rise;
    assign src_evt  = opt_r.ext_src ? edge_hit : (cyc_tick && !held);
    assign tmr_evt  = src_evt && !do_load;

    assign wdt_step  = cyc_tick && wdt_en && !clrwdt_i && !sleep_i;
    assign wdt_clear = do_clr || (do_slp && wdt_en);

    tmr_wdog_wdt #(.PERIOD(WDT_PERIOD), .W(WDT_W)) u_wdt (
        .clk   (clk),
        .rst   (rst),
        .step  (wdt_step),
        .clear (wdt_clear),
        .wrap  (wdt_wrap)
    );

    // Route the shared scaler according to its role.
    always_comb begin
        if (role == SCL_TMR) begin
            scl_step  = tmr_evt;
            scl_clear = do_load;
            tmr_bump  = scl_done;
            timeout   = wdt_wrap;
        end else begin
            scl_step  = wdt_wrap;
            scl_clear = do_clr || do_slp;
            tmr_bump  = tmr_evt;
            timeout   = scl_done;
        end
    end

    tmr_wdog_scaler u_scl (
        .clk   (clk),
        .rst   (rst),
        .role  (role),
        .rate  (opt_r.rate),
        .step  (scl_step),
        .clear (scl_clear),
        .done  (scl_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
        end else if (do_load) begin
            hold_cnt <= HOLD_W'(HOLD_TICKS);
        end else if (cyc_tick && held) begin
            hold_cnt <= hold_cnt - HOLD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else if (do_load) begin
            tmr_q <= tmr_wdata;
        end else if (tmr_bump) begin
            tmr_q <= tmr_q + TMR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wdt_rst_req <= 1'b0;
            to_upd      <= 1'b0;
            to_val      <= 1'b0;
            pd_upd      <= 1'b0;
            pd_val      <= 1'b0;
        end else begin
            wdt_rst_req <= timeout;
            to_upd      <= timeout || do_clr || do_slp;
            to_val      <= !timeout;
            pd_upd      <= do_clr || do_slp;
            pd_val      <= do_clr;
        end
    end
endmodule

// File: rtl/tmr_wdog_chk.sv
module tmr_wdog_chk
    import tmr_wdog_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cyc_tick,
    input logic             opt_we,
    input logic             wdt_en,
    input logic             tmr_we,
    input logic [TMR_W-1:0] tmr_wdata,
    input logic             clrwdt_i,
    input logic             sleep_i,
    input logic [TMR_W-1:0] tmr_q,
    input logic [OPT_W-1:0] opt_q,
    input logic             wdt_rst_req,
    input logic             to_upd,
    input logic             to_val,
    input logic             pd_upd,
    input logic             pd_val
);
    assert_opt_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(cyc_tick && opt_we) |=> $stable(opt_q));

    assert_tmr_step_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(tmr_q) |-> ($past(cyc_tick && tmr_we) || (tmr_q == $past(tmr_q) + 1'b1)));

    assert_tmr_load_R6: assert property (@(posedge clk) disable iff (rst)
        (cyc_tick && tmr_we) |=> (tmr_q == $past(tmr_wdata)));

    assert_rst_flags_R7: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_req |-> (to_upd && !to_val));

    assert_clr_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (cyc_tick && clrwdt_i) |=> (to_upd && to_val && pd_upd && pd_val && !wdt_rst_req));

    assert_sleep_flags_R10: assert property (@(posedge clk) disable iff (rst)
        (cyc_tick && sleep_i && !clrwdt_i) |=> (to_upd && to_val && pd_upd && !pd_val && !wdt_rst_req));

    assert_wdt_off_R11: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_req |-> $past(wdt_en && cyc_tick));

    assert_no_tick_R12: assert property (@(posedge clk) disable iff (rst)
        !cyc_tick |=> (!to_upd && !pd_upd && !wdt_rst_req));
endmodule

bind tmr_wdog tmr_wdog_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cyc_tick    (cyc_tick),
    .opt_we      (opt_we),
    .wdt_en      (wdt_en),
    .tmr_we      (tmr_we),
    .tmr_wdata   (tmr_wdata),
    .clrwdt_i    (clrwdt_i),
    .sleep_i     (sleep_i),
    .tmr_q       (tmr_q),
    .opt_q       (opt_q),
    .wdt_rst_req (wdt_rst_req),
    .to_upd      (to_upd),
    .to_val      (to_val),
    .pd_upd      (pd_upd),
    .pd_val      (pd_val)
);

// File: tb/tb_tmr_wdog.sv
module tb_tmr_wdog;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_tick = 1'b0;
    logic       cnt_pin = 1'b0;
    logic       opt_we = 1'b0;
    logic [5:0] opt_wdata = '0;
    logic       wdt_en = 1'b0;
    logic       tmr_we = 1'b0;
    logic [7:0] tmr_wdata = '0;
    logic       clrwdt_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic [7:0] tmr_q;
    logic [5:0] opt_q;
    logic       wdt_rst_req, to_upd, to_val, pd_upd, pd_val;

    int checks = 0;
    int failures = 0;
    int rst_seen = 0;
    logic cap_to_upd, cap_to_val, cap_pd_upd, cap_pd_val;

    always #5 clk = ~clk;

    tmr_wdog #(.WDT_PERIOD(10)) dut (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .cnt_pin(cnt_pin),
        .opt_we(opt_we), .opt_wdata(opt_wdata), .wdt_en(wdt_en),
        .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .clrwdt_i(clrwdt_i), .sleep_i(sleep_i),
        .tmr_q(tmr_q), .opt_q(opt_q), .wdt_rst_req(wdt_rst_req),
        .to_upd(to_upd), .to_val(to_val), .pd_upd(pd_upd), .pd_val(pd_val)
    );

    always @(negedge clk) if (!rst && wdt_rst_req) rst_seen++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wdt_en = 1'b0; cnt_pin = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        rst_seen = 0;
    endtask

    task automatic do_tick();
        cyc_tick = 1'b1;
        @(negedge clk);
        cap_to_upd = to_upd; cap_to_val = to_val;
        cap_pd_upd = pd_upd; cap_pd_val = pd_val;
        cyc_tick = 1'b0;
        opt_we = 1'b0; tmr_we = 1'b0; clrwdt_i = 1'b0; sleep_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic set_opt(input logic [5:0] v);
        opt_we = 1'b1; opt_wdata = v;
        do_tick();
    endtask

    task automatic pin_to(input logic v);
        cnt_pin = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 timer after reset", tmr_q, 0);
        chk("R1 option after reset", opt_q, 6'h3F);
        chk("R1 pulses after reset", {wdt_rst_req, to_upd, pd_upd}, 0);
        set_opt(6'h08);
        chk("R2 option loaded", opt_q, 6'h08);
        do_tick();
        chk("R1 no hold-off after reset", tmr_q, 1);
    endtask

    task automatic t_wrap();
        ticks(254);
        chk("R3 count to 255", tmr_q, 255);
        do_tick();
        chk("R3 wrap to 0", tmr_q, 0);
    endtask

    task automatic t_no_tick();
        opt_we = 1'b1; opt_wdata = 6'h00; tmr_we = 1'b1; tmr_wdata = 8'hAA; clrwdt_i = 1'b1;
        @(negedge clk);
        chk("R12 no flag pulse without tick", pd_upd, 0);
        @(negedge clk);
        opt_we = 1'b0; tmr_we = 1'b0; clrwdt_i = 1'b0;
        @(negedge clk);
        chk("R12 option unchanged", opt_q, 6'h08);
        chk("R12 timer unchanged", tmr_q, 0);
    endtask

    task automatic t_prescale();
        do_reset();
        set_opt(6'h01);
        ticks(3);
        chk("R4 rate1 before 4th", tmr_q, 0);
        do_tick();
        chk("R4 rate1 at 4th", tmr_q, 1);
        ticks(4);
        chk("R4 rate1 at 8th", tmr_q, 2);
        do_reset();
        set_opt(6'h07);
        ticks(255);
        chk("R4 rate7 before 256th", tmr_q, 0);
        do_tick();
        chk("R4 rate7 at 256th", tmr_q, 1);
    endtask

    task automatic t_write();
        do_reset();
        set_opt(6'h08);
        ticks(3);
        tmr_we = 1'b1; tmr_wdata = 8'h50;
        do_tick();
        chk("R6 load value", tmr_q, 8'h50);
        ticks(2);
        chk("R6 held two ticks", tmr_q, 8'h50);
        do_tick();
        chk("R6 counts on third tick", tmr_q, 8'h51);
        do_reset();
        set_opt(6'h01);
        ticks(3);
        tmr_we = 1'b1; tmr_wdata = 8'h10;
        do_tick();
        ticks(2);
        ticks(3);
        chk("R6 scaler cleared by write", tmr_q, 8'h10);
        do_tick();
        chk("R6 count after cleared scaler", tmr_q, 8'h11);
    endtask

    task automatic t_pin();
        do_reset();
        pin_to(1'b1);
        chk("R5 rising ignored in falling mode", tmr_q, 0);
        cnt_pin = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 not yet after two edges", tmr_q, 0);
        @(negedge clk);
        chk("R5 falling counted at third edge", tmr_q, 1);
        ticks(3);
        chk("R5 ticks ignored in pin mode", tmr_q, 1);
        set_opt(6'h28);
        pin_to(1'b1);
        chk("R5 rising counted", tmr_q, 2);
        pin_to(1'b0);
        chk("R5 falling ignored in rising mode", tmr_q, 2);
    endtask

    task automatic t_wdog();
        do_reset();
        set_opt(6'h00);
        wdt_en = 1'b1;
        ticks(9);
        chk("R7 no reset before period", rst_seen, 0);
        do_tick();
        chk("R7 reset at period", rst_seen, 1);
        chk("R7 time-out update", cap_to_upd, 1);
        chk("R7 time-out cleared", cap_to_val, 0);
        ticks(10);
        chk("R7 second period", rst_seen, 2);
        do_reset();
        set_opt(6'h0A);
        wdt_en = 1'b1;
        ticks(39);
        chk("R8 no reset before 4 wraps", rst_seen, 0);
        do_tick();
        chk("R8 reset after 4 wraps", rst_seen, 1);
        do_reset();
        set_opt(6'h00);
        ticks(50);
        chk("R11 disabled watchdog quiet", rst_seen, 0);
    endtask

    task automatic t_clr_sleep();
        do_reset();
        set_opt(6'h00);
        wdt_en = 1'b1;
        ticks(7);
        clrwdt_i = 1'b1;
        do_tick();
        chk("R9 flags on clear", {cap_to_upd, cap_to_val, cap_pd_upd, cap_pd_val}, 4'b1111);
        ticks(9);
        chk("R9 count restarted", rst_seen, 0);
        do_tick();
        chk("R9 full period after clear", rst_seen, 1);
        do_reset();
        set_opt(6'h0A);
        wdt_en = 1'b1;
        ticks(25);
        clrwdt_i = 1'b1;
        do_tick();
        ticks(39);
        chk("R9 postscaler cleared", rst_seen, 0);
        do_tick();
        chk("R9 postscaler full run", rst_seen, 1);
        do_reset();
        set_opt(6'h00);
        wdt_en = 1'b1;
        ticks(7);
        sleep_i = 1'b1;
        do_tick();
        chk("R10 flags on sleep", {cap_to_upd, cap_to_val, cap_pd_upd, cap_pd_val}, 4'b1110);
        ticks(9);
        chk("R10 count restarted", rst_seen, 0);
        do_tick();
        chk("R10 full period after sleep", rst_seen, 1);
    endtask

    initial begin
        t_reset();
        t_wrap();
        t_no_tick();
        t_prescale();
        t_write();
        t_pin();
        t_wdog();
        t_clr_sleep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule